// File: doc/BRIEF.md
# Fixed-Address Interrupt Vectoring Unit

This unit is the interrupt entry and exit logic for a small microcontroller core. It has six request lines: two external pins, three timers and a serial port. Each source has its own fixed vector address, and those addresses are 8 bytes apart, so each vector has room for a short handler. When an enabled request is pending and no interrupt is in service, the unit picks one source by a fixed order. It saves the address of the next instruction, then loads that source's vector into the program counter. No table is read.

By default the return address goes onto a byte-wide stack in internal memory, through an 8-bit stack pointer that the unit keeps. A build-time option keeps it in a link register instead, and then memory is not touched. When the core asserts the return input, the unit reloads the saved address into the program counter and reopens interrupt acceptance. Only one level is ever in service.

Top module: `irqv_entry`

## Requirements
- R1: The vector loaded on entry is 0x0003 + 8 × source index. Bit 0 is external pin 0 (0x0003), bit 1 is timer 0 (0x000B), bit 2 is external pin 1 (0x0013), bit 3 is timer 1 (0x001B), bit 4 is the serial port (0x0023) and bit 5 is timer 2 (0x002B).
- R2: When several eligible requests coincide, the lowest bit index wins.
- R3: A source is eligible only when its request bit, its enable bit and `glb_en` are all 1. With no eligible source, nothing is accepted.
- R4: In stack mode, the edge that accepts a source is followed by two write cycles. In the first, the low byte of the return address goes to SP+1. In the second, the high byte goes to SP+2, and `pc_load_o` is asserted with the vector in the same cycle. SP rises by one after each write.
- R5: In stack mode, `reti_i` sampled while in service causes two read cycles. The first reads the high byte at SP. The second reads the low byte at SP−1 and asserts `pc_load_o` with the restored address. SP ends two lower, and `in_service_o` then falls.
- R6: No source is accepted from the acceptance edge until the return completes. During that time `ack_o` stays 0 and nothing is written.
- R7: `reti_i` while not in service is ignored: no program-counter load, no write, and SP is unchanged.
- R8: After reset, SP is `SP_RESET` (0x07), `in_service_o` is 0, and `pc_load_o`, `mem_we_o` and `ack_o` are 0.
- R9: In link mode (`LINK_MODE`=1), the return address is held in a link register and memory is never written. The cycle after acceptance carries `pc_load_o` with the vector. The cycle after a sampled `reti_i` carries `pc_load_o` with the saved address.
- R10: `ack_o` is a one-hot pulse naming the accepted source. It is asserted in the first cycle after the acceptance edge.
- R11: The return address is `next_pc_i` as sampled at the acceptance edge. Later changes to `next_pc_i` have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req_i | input | 6 | Request lines, bit order as in R1 |
| irq_en_i | input | 6 | Per-source enable mask |
| glb_en | input | 1 | Global interrupt enable |
| next_pc_i | input | 16 | Address of the next instruction |
| reti_i | input | 1 | Return-from-interrupt request |
| mem_rdata_i | input | 8 | Stack read data, combinational from `mem_addr_o` |
| mem_we_o | output | 1 | Stack write strobe |
| mem_addr_o | output | 8 | Stack byte address |
| mem_wdata_o | output | 8 | Stack write data |
| sp_o | output | 8 | Current stack pointer |
| pc_load_o | output | 1 | Load `pc_value_o` into the program counter |
| pc_value_o | output | 16 | Vector or restored return address |
| in_service_o | output | 1 | An interrupt is being entered, served or returned from |
| ack_o | output | 6 | One-hot acceptance pulse |

## Verification
The assertions assume that stack memory returns, in the same cycle, the byte last written at `mem_addr_o`. They also assume that `reti_i` comes only from a core that is actually running a handler. The unit itself ignores a stray return, and the properties check that it does. The bench follows both assumptions. Its stack model is combinational read, registered write. It raises `reti_i` only once the service state is visible at the ports, except in the one directed case where a stray return is the point of the test. Request lines are driven for a single cycle, and they are held high during service only to show that entry stays blocked.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_LO,
    ST_PUSH_HI,
    ST_SERVE,
    ST_POP_HI,
    ST_POP_LO,
    ST_LINK,
    ST_UNLINK
  } seq_state_e;

  // fixed vector of a source: base plus index times spacing
  function automatic int unsigned vector_addr(input int unsigned idx,
                                              input int unsigned base,
                                              input int unsigned stride);
    return base + idx * stride;
  endfunction

endpackage

// File: rtl/irqv_pick.sv
module irqv_pick #(
  parameter int unsigned NSRC  = 6,
  parameter int unsigned IDX_W = 3
) (
  input  logic [NSRC-1:0]  req_i,
  input  logic [NSRC-1:0]  en_i,
  input  logic             glb_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);

  logic [NSRC-1:0] elig;
  logic [NSRC-1:0] grant;

  assign elig  = req_i & en_i & {NSRC{glb_i}};
  assign any_o = |elig;

  // a source wins only if every lower-indexed source is idle
  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_grant
      if (g == 0) begin : g_first
        assign grant[g] = elig[g];
      end else begin : g_rest
        assign grant[g] = elig[g] & ~(|elig[g-1:0]);
      end
    end
  endgenerate

  always_comb begin
    idx_o = '0;
    for (int k = 0; k < NSRC; k++) begin
      if (grant[k]) idx_o = IDX_W'(k);
    end
  end

endmodule

// File: rtl/irqv_vecgen.sv
module irqv_vecgen #(
  parameter int unsigned NSRC     = 6,
  parameter int unsigned IDX_W    = 3,
  parameter int unsigned PC_W     = 16,
  parameter int unsigned VEC_BASE = 3,
  parameter int unsigned VEC_STEP = 8
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [PC_W-1:0]  vec_o
);
  import irqv_pkg::*;

  logic [PC_W-1:0] vec_tab [NSRC];

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_vec
      assign vec_tab[g] = PC_W'(vector_addr(g, VEC_BASE, VEC_STEP));
    end
  endgenerate

  always_comb begin
    vec_o = vec_tab[0];
    for (int k = 0; k < NSRC; k++) begin
      if (idx_i == IDX_W'(k)) vec_o = vec_tab[k];
    end
  end

endmodule

// File: rtl/irqv_seq.sv
module irqv_seq #(
  parameter int unsigned PC_W      = 16,
  parameter int unsigned SP_W      = 8,
  parameter int unsigned IDX_W     = 3,
  parameter logic [7:0]  SP_RESET  = 8'h07,
  parameter bit          LINK_MODE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             any_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [PC_W-1:0]  next_pc_i,
  input  logic             reti_i,
  input  logic [7:0]       mem_rdata_i,
  input  logic [PC_W-1:0]  vec_i,
  output logic [IDX_W-1:0] src_o,
  output logic             ack_stb_o,
  output logic             entry_o,
  output logic             retload_o,
  output logic             mem_we_o,
  output logic [SP_W-1:0]  mem_addr_o,
  output logic [7:0]       mem_wdata_o,
  output logic [SP_W-1:0]  sp_o,
  output logic             pc_load_o,
  output logic [PC_W-1:0]  pc_value_o,
  output logic             in_service_o
);
  import irqv_pkg::*;

  localparam int unsigned HI_W = PC_W - 8;
  localparam seq_state_e  ST_ENTER  = LINK_MODE ? ST_LINK   : ST_PUSH_LO;
  localparam seq_state_e  ST_LEAVE  = LINK_MODE ? ST_UNLINK : ST_POP_HI;

  seq_state_e       state_q;
  logic [SP_W-1:0]  sp_q;
  logic [IDX_W-1:0] src_q;
  logic [PC_W-1:0]  ret_q;     // return address; acts as link register in link mode
  logic [HI_W-1:0]  hi_q;
  logic             pushing;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sp_q    <= SP_W'(SP_RESET);
      src_q   <= '0;
      ret_q   <= '0;
      hi_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (any_i) begin
            src_q   <= idx_i;
            ret_q   <= next_pc_i;
            state_q <= ST_ENTER;
          end
        end
        ST_PUSH_LO: begin
          sp_q    <= sp_q + SP_W'(1);
          state_q <= ST_PUSH_HI;
        end
        ST_PUSH_HI: begin
          sp_q    <= sp_q + SP_W'(1);
          state_q <= ST_SERVE;
        end
        ST_LINK:  state_q <= ST_SERVE;
        ST_SERVE: if (reti_i) state_q <= ST_LEAVE;
        ST_POP_HI: begin
          hi_q    <= HI_W'(mem_rdata_i);
          sp_q    <= sp_q - SP_W'(1);
          state_q <= ST_POP_LO;
        end
        ST_POP_LO: begin
          sp_q    <= sp_q - SP_W'(1);
          state_q <= ST_IDLE;
        end
        ST_UNLINK: state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  assign pushing      = (state_q == ST_PUSH_LO) || (state_q == ST_PUSH_HI);
  assign mem_we_o     = pushing;
  assign mem_addr_o   = pushing ? (sp_q + SP_W'(1)) : sp_q;
  assign mem_wdata_o  = (state_q == ST_PUSH_LO) ? ret_q[7:0] : 8'(ret_q[PC_W-1:8]);
  assign entry_o      = (state_q == ST_PUSH_HI) || (state_q == ST_LINK);
  assign retload_o    = (state_q == ST_POP_LO) || (state_q == ST_UNLINK);
  assign ack_stb_o    = (state_q == ST_PUSH_LO) || (state_q == ST_LINK);
  assign pc_load_o    = entry_o || retload_o;
  assign in_service_o = (state_q != ST_IDLE);
  assign sp_o         = sp_q;
  assign src_o        = src_q;

  always_comb begin
    if (entry_o)                     pc_value_o = vec_i;
    else if (state_q == ST_UNLINK)   pc_value_o = ret_q;
    else                             pc_value_o = {hi_q, mem_rdata_i};
  end

endmodule

// File: rtl/irqv_entry.sv
module irqv_entry #(
  parameter int unsigned NSRC      = 6,
  parameter int unsigned PC_W      = 16,
  parameter int unsigned SP_W      = 8,
  parameter logic [7:0]  SP_RESET  = 8'h07,
  parameter int unsigned VEC_BASE  = 3,
  parameter int unsigned VEC_STEP  = 8,
  parameter bit          LINK_MODE = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_req_i,
  input  logic [NSRC-1:0] irq_en_i,
  input  logic            glb_en,
  input  logic [PC_W-1:0] next_pc_i,
  input  logic            reti_i,
  input  logic [7:0]      mem_rdata_i,
  output logic            mem_we_o,
  output logic [SP_W-1:0] mem_addr_o,
  output logic [7:0]      mem_wdata_o,
  output logic [SP_W-1:0] sp_o,
  output logic            pc_load_o,
  output logic [PC_W-1:0] pc_value_o,
  output logic            in_service_o,
  output logic [NSRC-1:0] ack_o
);

  localparam int unsigned IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic             any_w;
  logic [IDX_W-1:0] pick_idx;
  logic [IDX_W-1:0] src_w;
  logic [PC_W-1:0]  vec_w;
  logic             ack_stb;
  logic             entry_w;     // vector is being loaded
  logic             retload_w;   // return address is being loaded

  irqv_pick #(.NSRC(NSRC), .IDX_W(IDX_W)) u_pick (
    .req_i (irq_req_i),
    .en_i  (irq_en_i),
    .glb_i (glb_en),
    .any_o (any_w),
    .idx_o (pick_idx)
  );

  irqv_vecgen #(
    .NSRC(NSRC), .IDX_W(IDX_W), .PC_W(PC_W),
    .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
  ) u_vec (
    .idx_i (src_w),
    .vec_o (vec_w)
  );

  irqv_seq #(
    .PC_W(PC_W), .SP_W(SP_W), .IDX_W(IDX_W),
    .SP_RESET(SP_RESET), .LINK_MODE(LINK_MODE)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .any_i        (any_w),
    .idx_i        (pick_idx),
    .next_pc_i    (next_pc_i),
    .reti_i       (reti_i),
    .mem_rdata_i  (mem_rdata_i),
    .vec_i        (vec_w),
    .src_o        (src_w),
    .ack_stb_o    (ack_stb),
    .entry_o      (entry_w),
    .retload_o    (retload_w),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .sp_o         (sp_o),
    .pc_load_o    (pc_load_o),
    .pc_value_o   (pc_value_o),
    .in_service_o (in_service_o)
  );

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_ack
      assign ack_o[g] = ack_stb && (src_w == IDX_W'(g));
    end
  endgenerate

endmodule

// File: rtl/irqv_entry_chk.sv
module irqv_entry_chk #(
  parameter int unsigned NSRC      = 6,
  parameter int unsigned PC_W      = 16,
  parameter int unsigned SP_W      = 8,
  parameter int unsigned VEC_BASE  = 3,
  parameter int unsigned VEC_STEP  = 8,
  parameter bit          LINK_MODE = 1'b0
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] irq_req_i,
  input logic [NSRC-1:0] irq_en_i,
  input logic            glb_en,
  input logic            reti_i,
  input logic            mem_we_o,
  input logic [SP_W-1:0] sp_o,
  input logic            pc_load_o,
  input logic [PC_W-1:0] pc_value_o,
  input logic            in_service_o,
  input logic [NSRC-1:0] ack_o,
  input logic            entry_w,
  input logic            retload_w
);

  localparam int unsigned VEC_END = VEC_BASE + NSRC * VEC_STEP;

  p_vector_r1: assert property (@(posedge clk) disable iff (!rst_n)
    entry_w |-> pc_load_o && (int'(pc_value_o) >= VEC_BASE) && (int'(pc_value_o) < VEC_END)
            && ((int'(pc_value_o) - VEC_BASE) % VEC_STEP == 0));

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_elig
      p_eligible_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o[g] |-> $past(irq_req_i[g] && irq_en_i[g] && glb_en));
    end
    if (LINK_MODE) begin : g_link
      p_link_nowrite_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_o);
    end else begin : g_stack
      p_push_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && !pc_load_o) |=> (mem_we_o && pc_load_o));
      p_sp_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |=> sp_o == $past(sp_o) + SP_W'(1));
    end
  endgenerate

  p_return_closes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    retload_w |=> !in_service_o);

  p_no_nest_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o != '0) |-> $past(!in_service_o));

  p_reti_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && !in_service_o) |=> !retload_w);

  p_ack_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_o));

endmodule

bind irqv_entry irqv_entry_chk #(
  .NSRC(NSRC), .PC_W(PC_W), .SP_W(SP_W),
  .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP), .LINK_MODE(LINK_MODE)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .irq_req_i    (irq_req_i),
  .irq_en_i     (irq_en_i),
  .glb_en       (glb_en),
  .reti_i       (reti_i),
  .mem_we_o     (mem_we_o),
  .sp_o         (sp_o),
  .pc_load_o    (pc_load_o),
  .pc_value_o   (pc_value_o),
  .in_service_o (in_service_o),
  .ack_o        (ack_o),
  .entry_w      (entry_w),
  .retload_w    (retload_w)
);

// File: tb/irqv_entry_bench.sv
module irqv_entry_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  irq_req = '0;
  logic [5:0]  irq_en = '0;
  logic        glb_en = 1'b0;
  logic [15:0] next_pc = '0;
  logic        reti = 1'b0;
  logic [7:0]  mem_rdata;

  logic        mem_we, l_mem_we;
  logic [7:0]  mem_addr, l_mem_addr, mem_wdata, l_mem_wdata, sp, l_sp;
  logic        pc_load, l_pc_load, in_service, l_in_service;
  logic [15:0] pc_value, l_pc_value;
  logic [5:0]  ack, l_ack;

  int checks = 0;
  int errs = 0;

  always #5 clk = ~clk;

  irqv_entry u_irqv_entry (
    .clk(clk), .rst_n(rst_n), .irq_req_i(irq_req), .irq_en_i(irq_en), .glb_en(glb_en),
    .next_pc_i(next_pc), .reti_i(reti), .mem_rdata_i(mem_rdata),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .sp_o(sp),
    .pc_load_o(pc_load), .pc_value_o(pc_value), .in_service_o(in_service), .ack_o(ack)
  );

  irqv_entry #(.LINK_MODE(1'b1)) u_irqv_entry_lnk (
    .clk(clk), .rst_n(rst_n), .irq_req_i(irq_req), .irq_en_i(irq_en), .glb_en(glb_en),
    .next_pc_i(next_pc), .reti_i(reti), .mem_rdata_i(8'h00),
    .mem_we_o(l_mem_we), .mem_addr_o(l_mem_addr), .mem_wdata_o(l_mem_wdata), .sp_o(l_sp),
    .pc_load_o(l_pc_load), .pc_value_o(l_pc_value), .in_service_o(l_in_service), .ack_o(l_ack)
  );

  // stack memory: registered write, combinational read
  logic [7:0] stk [256];
  always @(posedge clk) if (mem_we) stk[mem_addr] <= mem_wdata;
  assign mem_rdata = stk[mem_addr];

  // {req, en, glb, expected source (7 = none)}
  localparam int NV = 13;
  localparam logic [15:0] VEC_TBL [NV] = '{
    {6'b000001, 6'b111111, 1'b1, 3'd0},
    {6'b000010, 6'b111111, 1'b1, 3'd1},
    {6'b000100, 6'b111111, 1'b1, 3'd2},
    {6'b001000, 6'b111111, 1'b1, 3'd3},
    {6'b010000, 6'b111111, 1'b1, 3'd4},
    {6'b100000, 6'b111111, 1'b1, 3'd5},
    {6'b111111, 6'b111111, 1'b1, 3'd0},
    {6'b111110, 6'b111111, 1'b1, 3'd1},
    {6'b101100, 6'b111111, 1'b1, 3'd2},
    {6'b110000, 6'b111111, 1'b1, 3'd4},
    {6'b111111, 6'b110000, 1'b1, 3'd4},
    {6'b111111, 6'b111111, 1'b0, 3'd7},
    {6'b010000, 6'b101111, 1'b1, 3'd7}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_vec(input int idx);
    return 16'(8 * idx + 3);
  endfunction

  task automatic run_vec(input logic [5:0] req, input logic [5:0] en, input logic g,
                         input int exp, input logic [15:0] rpc, input logic [7:0] sp0);
    @(negedge clk);
    irq_req = req; irq_en = en; glb_en = g; next_pc = rpc;
    @(negedge clk);
    irq_req = '0; next_pc = 16'hDEAD;    // R11: later changes must not matter
    if (exp == 7) begin
      chk(ack == 6'd0, "R3 ack with nothing eligible", 32'(ack), 0);
      chk(!mem_we && !in_service, "R3 no entry", {mem_we, in_service}, 0);
      chk(!l_pc_load, "R3 link no load", 32'(l_pc_load), 0);
      chk(sp == sp0, "R3 sp unchanged", 32'(sp), 32'(sp0));
      return;
    end
    chk(ack == 6'(1 << exp), "R2 R10 ack one-hot winner", 32'(ack), 32'(1 << exp));
    chk(mem_we && mem_addr == sp0 + 8'd1 && mem_wdata == rpc[7:0], "R4 low byte push",
        {mem_we, mem_addr, mem_wdata}, {1'b1, sp0 + 8'd1, rpc[7:0]});
    chk(l_pc_load && l_pc_value == exp_vec(exp) && !l_mem_we, "R9 link entry vector",
        {l_pc_load, l_mem_we, l_pc_value}, {2'b10, exp_vec(exp)});
    chk(l_ack == 6'(1 << exp), "R10 link ack", 32'(l_ack), 32'(1 << exp));
    @(negedge clk);
    chk(mem_we && mem_addr == sp0 + 8'd2 && mem_wdata == rpc[15:8], "R4 R11 high byte push",
        {mem_we, mem_addr, mem_wdata}, {1'b1, sp0 + 8'd2, rpc[15:8]});
    chk(pc_load && pc_value == exp_vec(exp), "R1 vector load", {pc_load, pc_value}, {1'b1, exp_vec(exp)});
    @(negedge clk);
    chk(sp == sp0 + 8'd2 && in_service && !pc_load, "R4 sp after push", {in_service, sp}, {1'b1, sp0 + 8'd2});
    irq_req = 6'h3F; irq_en = 6'h3F; glb_en = 1'b1;   // R6: must not nest
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      chk(ack == 6'd0 && !mem_we && l_ack == 6'd0, "R6 blocked while in service",
          {ack, mem_we, l_ack}, 0);
    end
    irq_req = '0;
    reti = 1'b1;
    @(negedge clk);
    reti = 1'b0;
    chk(!pc_load && mem_addr == sp0 + 8'd2 && !mem_we, "R5 pop high read cycle",
        {pc_load, mem_we, mem_addr}, {2'b00, sp0 + 8'd2});
    chk(l_pc_load && l_pc_value == rpc, "R9 link return", {l_pc_load, l_pc_value}, {1'b1, rpc});
    @(negedge clk);
    chk(pc_load && pc_value == rpc, "R5 restored address", {pc_load, pc_value}, {1'b1, rpc});
    @(negedge clk);
    chk(sp == sp0 && !in_service && !l_in_service, "R5 sp and service after return",
        {in_service, l_in_service, sp}, {2'b00, sp0});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk(sp == 8'h07 && l_sp == 8'h07, "R8 sp reset", {l_sp, sp}, 16'h0707);
    chk(!in_service && !pc_load && !mem_we && ack == 0, "R8 quiet after reset",
        {in_service, pc_load, mem_we, ack}, 0);
    // R7 stray return
    reti = 1'b1;
    @(negedge clk);
    reti = 1'b0;
    @(negedge clk);
    chk(!pc_load && !l_pc_load && !mem_we && sp == 8'h07 && !in_service,
        "R7 stray return ignored", {pc_load, l_pc_load, mem_we, in_service, sp}, 32'h07);
    for (int v = 0; v < NV; v++) begin
      run_vec(VEC_TBL[v][15:10], VEC_TBL[v][9:4], VEC_TBL[v][3], int'(VEC_TBL[v][2:0]),
              16'h1230 + 16'(v * 16'h0111), 8'h07);
    end
    // R11: back-to-back entries reuse the same stack slots
    run_vec(6'b000001, 6'b111111, 1'b1, 0, 16'hA55A, 8'h07);
    $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
    $finish;
  end

endmodule